// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block decides whether one memory access may proceed through a segment while the processor runs in protected mode with long mode off. In a single combinational pass it takes the selector, base, limit and attribute bits of the chosen segment, together with the kind of access, its size and the virtual address. It then reports a general-protection fault with a reason code, or lets the access pass. It also returns the linear address trimmed to the address width in force. Descriptor loading and page translation are handled elsewhere. The block only judges the access that the segment unit presents to it.

Three tests run side by side. The first looks for a null selector, with a parameter list of segments that may be null. The second checks the read and write rights of the ordinary segments. The third compares the offset range against the limit, and that comparison turns around for expand-down segments. When more than one test fails, a fixed priority picks the single cause that is reported.

Top module: `seg_prot_checker`

## Requirements
- R1: The null-selector, rights and limit tests apply only when `prot_en` is 1 and `long_mode` is 0. Otherwise `gp_fault` is 0 and `gp_cause` is 0.
- R2: A selector of zero raises cause 1 (null selector), unless `seg_idx` is in the exempt list. The default exempt segments are 7, 8, 9 and 10.
- R3: For a segment with index 0 to 7, a write (`acc_kind` = 1) or any access with `store_chk` = 1 raises cause 2 (rights) when `attr_wr` is 0.
- R4: For a segment with index 0 to 7, a read (`acc_kind` = 0) raises cause 2 when `attr_rd` is 0. Execute (`acc_kind` = 2) and the spare code 3 are not checked against `attr_rd`.
- R5: The address width in bits is 8 shifted left by the log size. `addr_ovr` = 1 selects `alt_log` and `addr_ovr` = 0 selects `def_log`.
- R6: The start offset is (`vaddr` − `seg_base`) reduced modulo 2^width. The end offset is the start offset plus `acc_size` minus 1, computed without wrapping. An `acc_size` of 0 counts as one byte.
- R7: For a segment that is not expand-down, cause 3 (limit) is raised when the start offset or the end offset is greater than `seg_limit`.
- R8: For a segment with index 0 to 7 and `attr_xdn` = 1, cause 3 is raised when the start offset or the end offset is less than or equal to `seg_limit`.
- R9: When several tests fail, the null selector wins over the rights test, and the rights test wins over the limit test. `gp_fault` is 1 exactly when `gp_cause` is not 0.
- R10: With `prot_en` = 0, `lin_addr` equals `vaddr`. With `prot_en` = 1, `lin_addr` keeps only its low 32 bits, unless `sub64_mode` = 1 and `addr_ovr` = 0, in which case all bits are kept.
- R11: For segment indices above 7, `attr_rd`, `attr_wr` and `attr_xdn` have no effect. Those segments always get the normal, non-expand-down limit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prot_en | input | 1 | Protected mode enabled |
| long_mode | input | 1 | Long mode active; skips all segment tests |
| sub64_mode | input | 1 | 64-bit submode active |
| addr_ovr | input | 1 | Address-size override on this access |
| def_log | input | 2 | Default log2 of address width in bytes |
| alt_log | input | 2 | Alternate log2 of address width in bytes |
| seg_idx | input | SEG_W | Segment index |
| seg_sel | input | SEL_W | Segment selector value |
| seg_base | input | VA_W | Segment base |
| seg_limit | input | LIM_W | Segment limit |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_xdn | input | 1 | Segment expands down |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 spare (treated as execute) |
| store_chk | input | 1 | Access must be checked as if it were a store |
| acc_size | input | SIZE_W | Access size in bytes (0 counts as 1) |
| vaddr | input | VA_W | Virtual address of the access |
| gp_fault | output | 1 | General-protection fault |
| gp_cause | output | 2 | 0 none, 1 null selector, 2 rights, 3 limit |
| lin_addr | output | VA_W | Linear address after width trimming |

## Verification
The bench builds the block with its default parameters. These are a 64-bit address, a 32-bit limit, a 4-bit access size and a 4-bit segment index. The exempt list is 7 to 10 and the checked range is 0 to 7. With these values one exempt segment (7) lies inside the checked range and three lie outside it, so both kinds of exemption are exercised. All four address widths are reachable, including the full 64-bit width where no modulo reduction takes place. Access sizes up to 15 let the end offset cross both the limit and the 2^width boundary. Random vectors place the address within a few bytes of the base plus the limit, so the boundaries of both the normal and the expand-down comparisons are hit often.

// File: rtl/seg_chk_pkg.sv
// Shared encodings for the segment protection checker.
package seg_chk_pkg;

    // Kind of memory access presented to the checker.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    // Reported reason for a general-protection fault.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NULL   = 2'd1,
        CAUSE_RIGHTS = 2'd2,
        CAUSE_LIMIT  = 2'd3
    } gp_cause_e;

endpackage

// File: rtl/seg_null_sel.sv
// Null-selector test.
// Flags a zero selector unless the segment index appears in a parameter
// list of exempt segments. Assumes the list is packed with entry 0 in
// the low SEG_W bits.
module seg_null_sel #(
    parameter int SEG_W    = 4,
    parameter int SEL_W    = 16,
    parameter int N_EXEMPT = 4,
    parameter logic [N_EXEMPT*SEG_W-1:0] EXEMPT_LIST = '0
) (
    input  logic [SEG_W-1:0] seg_idx,
    input  logic [SEL_W-1:0] seg_sel,
    output logic             null_flt
);
    logic [N_EXEMPT-1:0] hit;

    // One comparator per exempt entry.
    for (genvar g = 0; g < N_EXEMPT; g++) begin : g_exempt
        assign hit[g] = (seg_idx == EXEMPT_LIST[g*SEG_W +: SEG_W]);
    end

    // Zero selector on a segment that is not exempt.
    always_comb begin
        null_flt = (seg_sel == '0) && !(|hit);
    end
endmodule

// File: rtl/seg_rights.sv
// Read and write rights test.
// Applies only to segments whose index lies in [CHK_LO, CHK_HI]. It also
// returns whether the expand-down attribute takes effect. Execute and the
// spare access code are never checked against the readable bit.
module seg_rights
    import seg_chk_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int CHK_LO = 0,
    parameter int CHK_HI = 7
) (
    input  logic [SEG_W-1:0] seg_idx,
    input  logic             attr_rd,
    input  logic             attr_wr,
    input  logic             attr_xdn,
    input  logic [1:0]       acc_kind,
    input  logic             store_chk,
    output logic             perm_flt,
    output logic             xdn_eff
);
    localparam int IDX_W = SEG_W + 1;

    logic      in_range;
    acc_kind_e kind;
    logic      wants_wr;
    logic      wants_rd;

    // Decide whether the segment belongs to the checked group.
    always_comb begin
        in_range = ({1'b0, seg_idx} >= IDX_W'(CHK_LO)) &&
                   ({1'b0, seg_idx} <= IDX_W'(CHK_HI));
    end

    // Work out which rights the access needs.
    always_comb begin
        kind     = acc_kind_e'(acc_kind);
        wants_wr = (kind == ACC_WRITE) || store_chk;
        wants_rd = (kind == ACC_READ);
    end

    // Raise the rights fault and qualify expand-down.
    always_comb begin
        perm_flt = in_range && ((wants_wr && !attr_wr) || (wants_rd && !attr_rd));
        xdn_eff  = in_range && attr_xdn;
    end
endmodule

// File: rtl/seg_offset.sv
// Offset generator.
// Picks the address width from the log size, reduces (vaddr - base) to
// that width, and forms the end offset one bit wider so it cannot wrap.
// Assumes VA_W >= 8.
module seg_offset #(
    parameter int VA_W   = 64,
    parameter int SIZE_W = 4
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   seg_base,
    input  logic              addr_ovr,
    input  logic [1:0]        def_log,
    input  logic [1:0]        alt_log,
    input  logic [SIZE_W-1:0] acc_size,
    output logic [VA_W-1:0]   off_start,
    output logic [VA_W:0]     off_end
);
    localparam int WBITS_W = 8;

    logic [1:0]         log_sel;
    logic [WBITS_W-1:0] width_bits;
    logic [VA_W-1:0]    width_mask;
    logic [VA_W-1:0]    raw_off;
    logic [SIZE_W-1:0]  size_eff;

    // Choose the active log size and convert it into a bit count.
    always_comb begin
        log_sel    = addr_ovr ? alt_log : def_log;
        width_bits = WBITS_W'(8) << log_sel;
    end

    // Build a mask with ones below the active width.
    always_comb begin
        for (int i = 0; i < VA_W; i++) begin
            width_mask[i] = (i < int'(width_bits));
        end
    end

    // Reduce the start offset and form the end offset.
    always_comb begin
        raw_off   = vaddr - seg_base;
        off_start = raw_off & width_mask;
        size_eff  = (acc_size == '0) ? SIZE_W'(1) : acc_size;
        off_end   = {1'b0, off_start} + (VA_W+1)'(size_eff) - (VA_W+1)'(1);
    end
endmodule

// File: rtl/seg_limit_cmp.sv
// Limit comparison.
// A normal segment allows offsets up to the limit. An expand-down segment
// allows only offsets above it. Assumes LIM_W <= VA_W.
module seg_limit_cmp #(
    parameter int VA_W  = 64,
    parameter int LIM_W = 32
) (
    input  logic [VA_W-1:0]  off_start,
    input  logic [VA_W:0]    off_end,
    input  logic [LIM_W-1:0] seg_limit,
    input  logic             xdn_eff,
    output logic             lim_flt
);
    logic [VA_W:0] lim_ext;
    logic          start_above;
    logic          end_above;

    // Widen the limit and compare both ends of the access against it.
    always_comb begin
        lim_ext     = (VA_W+1)'(seg_limit);
        start_above = ({1'b0, off_start} > lim_ext);
        end_above   = (off_end > lim_ext);
    end

    // Pick the test that matches the segment direction.
    always_comb begin
        if (xdn_eff) lim_flt = !start_above || !end_above;
        else         lim_flt = start_above || end_above;
    end
endmodule

// File: rtl/seg_addr_out.sv
// Linear address trimming.
// Outside protected mode the address passes through unchanged. Inside it,
// only the low NARROW_W bits are kept unless 64-bit submode is active and
// there is no size override.
module seg_addr_out #(
    parameter int VA_W     = 64,
    parameter int NARROW_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            prot_en,
    input  logic            sub64_mode,
    input  logic            addr_ovr,
    output logic [VA_W-1:0] lin_addr
);
    localparam logic [VA_W-1:0] NARROW_MASK = (VA_W > NARROW_W) ?
        ((VA_W'(1) << NARROW_W) - VA_W'(1)) : '1;

    logic keep_full;

    // Decide whether the full width survives and apply the mask.
    always_comb begin
        keep_full = !prot_en || (sub64_mode && !addr_ovr);
        lin_addr  = keep_full ? vaddr : (vaddr & NARROW_MASK);
    end
endmodule

// File: rtl/seg_prot_checker.sv
// Segment protection and limit checker (top).
// Purely combinational. It runs the null-selector, rights and limit tests
// in parallel, reports one cause by priority, and trims the linear
// address. The tests are active only in protected mode with long mode off.
module seg_prot_checker
    import seg_chk_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int SEL_W    = 16,
    parameter int LIM_W    = 32,
    parameter int SIZE_W   = 4,
    parameter int SEG_W    = 4,
    parameter int N_EXEMPT = 4,
    parameter logic [N_EXEMPT*SEG_W-1:0] EXEMPT_LIST = {4'd10, 4'd9, 4'd8, 4'd7},
    parameter int CHK_LO   = 0,
    parameter int CHK_HI   = 7,
    parameter int NARROW_W = 32
) (
    input  logic              prot_en,
    input  logic              long_mode,
    input  logic              sub64_mode,
    input  logic              addr_ovr,
    input  logic [1:0]        def_log,
    input  logic [1:0]        alt_log,
    input  logic [SEG_W-1:0]  seg_idx,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic [VA_W-1:0]   seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic              attr_xdn,
    input  logic [1:0]        acc_kind,
    input  logic              store_chk,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [VA_W-1:0]   vaddr,
    output logic              gp_fault,
    output logic [1:0]        gp_cause,
    output logic [VA_W-1:0]   lin_addr
);
    logic            null_flt;
    logic            perm_flt;
    logic            xdn_eff;
    logic            lim_flt;
    logic            chk_en;
    logic [VA_W-1:0] off_start;
    logic [VA_W:0]   off_end;
    gp_cause_e       cause;

    seg_null_sel #(
        .SEG_W(SEG_W), .SEL_W(SEL_W), .N_EXEMPT(N_EXEMPT), .EXEMPT_LIST(EXEMPT_LIST)
    ) u_null (
        .seg_idx(seg_idx), .seg_sel(seg_sel), .null_flt(null_flt)
    );

    seg_rights #(
        .SEG_W(SEG_W), .CHK_LO(CHK_LO), .CHK_HI(CHK_HI)
    ) u_rights (
        .seg_idx(seg_idx), .attr_rd(attr_rd), .attr_wr(attr_wr), .attr_xdn(attr_xdn),
        .acc_kind(acc_kind), .store_chk(store_chk), .perm_flt(perm_flt), .xdn_eff(xdn_eff)
    );

    seg_offset #(
        .VA_W(VA_W), .SIZE_W(SIZE_W)
    ) u_off (
        .vaddr(vaddr), .seg_base(seg_base), .addr_ovr(addr_ovr), .def_log(def_log),
        .alt_log(alt_log), .acc_size(acc_size), .off_start(off_start), .off_end(off_end)
    );

    seg_limit_cmp #(
        .VA_W(VA_W), .LIM_W(LIM_W)
    ) u_lim (
        .off_start(off_start), .off_end(off_end), .seg_limit(seg_limit),
        .xdn_eff(xdn_eff), .lim_flt(lim_flt)
    );

    seg_addr_out #(
        .VA_W(VA_W), .NARROW_W(NARROW_W)
    ) u_addr (
        .vaddr(vaddr), .prot_en(prot_en), .sub64_mode(sub64_mode),
        .addr_ovr(addr_ovr), .lin_addr(lin_addr)
    );

    // Enable the tests only in protected, non-long mode.
    always_comb begin
        chk_en = prot_en && !long_mode;
    end

    // Priority selection: null selector, then rights, then limit.
    always_comb begin
        cause = CAUSE_NONE;
        if (chk_en) begin
            if (null_flt)      cause = CAUSE_NULL;
            else if (perm_flt) cause = CAUSE_RIGHTS;
            else if (lim_flt)  cause = CAUSE_LIMIT;
        end
        gp_cause = cause;
        gp_fault = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/seg_prot_checker_sva.sv
// Assertion checker for seg_prot_checker. It is attached through bind.
// The block is combinational, so every check is an immediate assertion
// that is evaluated whenever its inputs change.
module seg_prot_checker_sva #(
    parameter int VA_W     = 64,
    parameter int SEL_W    = 16,
    parameter int LIM_W    = 32,
    parameter int SIZE_W   = 4,
    parameter int SEG_W    = 4,
    parameter int CHK_LO   = 0,
    parameter int CHK_HI   = 7,
    parameter int NARROW_W = 32
) (
    input logic              prot_en,
    input logic              long_mode,
    input logic              sub64_mode,
    input logic              addr_ovr,
    input logic [1:0]        def_log,
    input logic [1:0]        alt_log,
    input logic [SEG_W-1:0]  seg_idx,
    input logic [SEL_W-1:0]  seg_sel,
    input logic [VA_W-1:0]   seg_base,
    input logic [LIM_W-1:0]  seg_limit,
    input logic              attr_rd,
    input logic              attr_wr,
    input logic              attr_xdn,
    input logic [1:0]        acc_kind,
    input logic              store_chk,
    input logic [SIZE_W-1:0] acc_size,
    input logic [VA_W-1:0]   vaddr,
    input logic              gp_fault,
    input logic [1:0]        gp_cause,
    input logic [VA_W-1:0]   lin_addr
);
    localparam int IDX_W = SEG_W + 1;

    logic in_rng;

    // Port-level relations that must hold for every input combination.
    always_comb begin
        in_rng = ({1'b0, seg_idx} >= IDX_W'(CHK_LO)) && ({1'b0, seg_idx} <= IDX_W'(CHK_HI));

        a_r1_quiet_outside: assert (!(!prot_en || long_mode) || (!gp_fault && gp_cause == 2'd0))
            else $error("R1: fault outside checked mode");

        a_r2_null_needs_zero: assert (gp_cause != 2'd1 || seg_sel == '0)
            else $error("R2: null cause with nonzero selector");

        a_r3_rights_reason: assert (gp_cause != 2'd2 ||
                (((acc_kind == 2'd1) || store_chk) && !attr_wr) ||
                ((acc_kind == 2'd0) && !attr_rd))
            else $error("R3: rights cause without missing right");

        a_r11_outside_no_rights: assert (in_rng || gp_cause != 2'd2)
            else $error("R11: rights cause on unchecked segment");

        a_r10_narrow_addr: assert (!(prot_en && !(sub64_mode && !addr_ovr)) ||
                (lin_addr >> NARROW_W) == '0)
            else $error("R10: high address bits survive");

        a_r10_real_mode_addr: assert (prot_en || lin_addr == vaddr)
            else $error("R10: real-mode address changed");
    end
endmodule

bind seg_prot_checker seg_prot_checker_sva #(
    .VA_W(VA_W), .SEL_W(SEL_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W), .SEG_W(SEG_W),
    .CHK_LO(CHK_LO), .CHK_HI(CHK_HI), .NARROW_W(NARROW_W)
) u_sva (.*);

// File: tb/seg_prot_checker_tb_top.sv
// Testbench for seg_prot_checker: directed corner cases plus seeded random.
module seg_prot_checker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        prot_en, long_mode, sub64_mode, addr_ovr;
    logic [1:0]  def_log, alt_log;
    logic [3:0]  seg_idx;
    logic [15:0] seg_sel;
    logic [63:0] seg_base;
    logic [31:0] seg_limit;
    logic        attr_rd, attr_wr, attr_xdn;
    logic [1:0]  acc_kind;
    logic        store_chk;
    logic [3:0]  acc_size;
    logic [63:0] vaddr;
    logic        gp_fault;
    logic [1:0]  gp_cause;
    logic [63:0] lin_addr;

    int n_tests = 0;
    int n_fail  = 0;

    seg_prot_checker dut_i (
        .prot_en(prot_en), .long_mode(long_mode), .sub64_mode(sub64_mode),
        .addr_ovr(addr_ovr), .def_log(def_log), .alt_log(alt_log),
        .seg_idx(seg_idx), .seg_sel(seg_sel), .seg_base(seg_base),
        .seg_limit(seg_limit), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .attr_xdn(attr_xdn), .acc_kind(acc_kind), .store_chk(store_chk),
        .acc_size(acc_size), .vaddr(vaddr), .gp_fault(gp_fault),
        .gp_cause(gp_cause), .lin_addr(lin_addr)
    );

    // Expected cause from the requirements.
    function automatic logic [1:0] exp_cause();
        logic        exempt, inr, xdn, lflt;
        logic [1:0]  lg;
        int          w;
        logic [63:0] msk, off;
        logic [64:0] endo, lim;
        if (!(prot_en && !long_mode)) return 2'd0;
        exempt = (seg_idx == 4'd7) || (seg_idx == 4'd8) || (seg_idx == 4'd9) || (seg_idx == 4'd10);
        inr    = (seg_idx <= 4'd7);
        if (seg_sel == 16'd0 && !exempt) return 2'd1;
        if (inr && ((((acc_kind == 2'd1) || store_chk) && !attr_wr) ||
                    ((acc_kind == 2'd0) && !attr_rd))) return 2'd2;
        lg   = addr_ovr ? alt_log : def_log;
        w    = 8 * (1 << lg);
        msk  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        off  = (vaddr - seg_base) & msk;
        endo = {1'b0, off} + 65'(acc_size == 4'd0 ? 4'd1 : acc_size) - 65'd1;
        lim  = {33'd0, seg_limit};
        xdn  = inr && attr_xdn;
        if (xdn) lflt = ({1'b0, off} <= lim) || (endo <= lim);
        else     lflt = ({1'b0, off} > lim) || (endo > lim);
        return lflt ? 2'd3 : 2'd0;
    endfunction

    // Expected linear address from the requirements.
    function automatic logic [63:0] exp_addr();
        if (!prot_en) return vaddr;
        if (sub64_mode && !addr_ovr) return vaddr;
        return {32'd0, vaddr[31:0]};
    endfunction

    // Compare one vector against the requirement tag and expected cause.
    task automatic check(input string tag, input logic [1:0] want_cause);
        logic [63:0] want_addr;
        #1;
        want_addr = exp_addr();
        n_tests++;
        if (gp_cause !== want_cause || gp_fault !== (want_cause != 2'd0) || lin_addr !== want_addr) begin
            n_fail++;
            $display("FAIL %s: cause=%0d fault=%0b addr=%h expected cause=%0d fault=%0b addr=%h",
                     tag, gp_cause, gp_fault, lin_addr, want_cause, (want_cause != 2'd0), want_addr);
        end
    endtask

    // Put all inputs into a quiet protected-mode state.
    task automatic base_setup();
        @(negedge clk);
        prot_en = 1; long_mode = 0; sub64_mode = 0; addr_ovr = 0;
        def_log = 2'd2; alt_log = 2'd1; seg_idx = 4'd3; seg_sel = 16'h0010;
        seg_base = 64'h1000; seg_limit = 32'hFF; attr_rd = 1; attr_wr = 1; attr_xdn = 0;
        acc_kind = 2'd0; store_chk = 0; acc_size = 4'd4; vaddr = 64'h1010;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        {prot_en, long_mode, sub64_mode, addr_ovr, attr_rd, attr_wr, attr_xdn, store_chk} = '0;
        def_log = 0; alt_log = 0; seg_idx = 0; seg_sel = 0; seg_base = 0; seg_limit = 0;
        acc_kind = 0; acc_size = 0; vaddr = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle inputs", 2'd0);

        // R1: long mode skips everything, even a null selector.
        base_setup(); long_mode = 1; seg_sel = 0; check("R1 long mode", 2'd0);
        // R2: null selector on a plain segment, then on exempt ones.
        base_setup(); seg_sel = 0; check("R2 null", 2'd1);
        base_setup(); seg_sel = 0; seg_idx = 4'd8; check("R2 exempt 8", 2'd0);
        base_setup(); seg_sel = 0; seg_idx = 4'd7; check("R2 exempt 7", 2'd0);
        // R3: write and store-check on a non-writable segment.
        base_setup(); attr_wr = 0; acc_kind = 2'd1; check("R3 write", 2'd2);
        base_setup(); attr_wr = 0; store_chk = 1; check("R3 store check", 2'd2);
        base_setup(); attr_wr = 0; check("R3 read ok", 2'd0);
        // R4: read needs readable, execute does not.
        base_setup(); attr_rd = 0; check("R4 read", 2'd2);
        base_setup(); attr_rd = 0; acc_kind = 2'd2; check("R4 exec", 2'd0);
        // R7: normal limit, last byte exactly at the limit, then one past.
        base_setup(); vaddr = 64'h10FC; check("R7 at limit", 2'd0);
        base_setup(); vaddr = 64'h10FC; acc_size = 4'd5; check("R7 past limit", 2'd3);
        base_setup(); vaddr = 64'h1100; acc_size = 4'd1; check("R7 start past", 2'd3);
        // R8: expand-down limit tests.
        base_setup(); attr_xdn = 1; vaddr = 64'h1100; check("R8 above limit", 2'd0);
        base_setup(); attr_xdn = 1; vaddr = 64'h10FF; check("R8 at limit", 2'd3);
        // R6 and R5: 16-bit wrap of the offset and override to 32 bits.
        base_setup(); def_log = 2'd1; seg_base = 64'h10; vaddr = 64'h8; seg_limit = 32'hFFFF;
        acc_size = 4'd8; check("R6 wrap fits", 2'd0);
        base_setup(); def_log = 2'd1; seg_base = 64'h10; vaddr = 64'h8; seg_limit = 32'hFFFF;
        acc_size = 4'd9; check("R6 end crosses", 2'd3);
        base_setup(); def_log = 2'd1; alt_log = 2'd2; addr_ovr = 1; seg_base = 64'h10;
        vaddr = 64'h8; seg_limit = 32'hFFFF; acc_size = 4'd1; check("R5 override width", 2'd3);
        base_setup(); acc_size = 4'd0; vaddr = 64'h10FF; check("R6 size zero", 2'd0);
        // R9: priority between causes.
        base_setup(); seg_sel = 0; attr_wr = 0; acc_kind = 2'd1; check("R9 null over rights", 2'd1);
        base_setup(); attr_wr = 0; acc_kind = 2'd1; vaddr = 64'h2000; check("R9 rights over limit", 2'd2);
        // R10: address trimming.
        base_setup(); long_mode = 1; sub64_mode = 1; vaddr = 64'hDEAD_BEEF_1234_5678; check("R10 full", 2'd0);
        base_setup(); long_mode = 1; sub64_mode = 1; addr_ovr = 1; vaddr = 64'hDEAD_BEEF_1234_5678; check("R10 override", 2'd0);
        base_setup(); prot_en = 0; vaddr = 64'hDEAD_BEEF_1234_5678; check("R10 real mode", 2'd0);
        // R11: attributes ignored outside the checked range.
        base_setup(); seg_idx = 4'd9; attr_wr = 0; attr_rd = 0; attr_xdn = 1; acc_kind = 2'd1;
        check("R11 ignored attrs", 2'd0);

        // Random vectors clustered around the limit boundary.
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] dlt;
            @(negedge clk);
            prot_en    = ($urandom % 5) != 0;
            long_mode  = ($urandom % 6) == 0;
            sub64_mode = $urandom % 2;
            addr_ovr   = $urandom % 2;
            def_log    = 2'($urandom);
            alt_log    = 2'($urandom);
            seg_idx    = 4'($urandom);
            seg_sel    = (($urandom % 6) == 0) ? 16'd0 : 16'($urandom);
            seg_base   = {32'($urandom), 32'($urandom)};
            seg_limit  = (($urandom % 2) == 0) ? 32'($urandom % 512) : 32'($urandom);
            attr_rd    = ($urandom % 5) != 0;
            attr_wr    = ($urandom % 4) != 0;
            attr_xdn   = ($urandom % 4) == 0;
            acc_kind   = 2'($urandom);
            store_chk  = ($urandom % 8) == 0;
            acc_size   = 4'($urandom);
            dlt        = 64'($signed($urandom % 16) - 8);
            vaddr      = (($urandom % 4) == 0) ? {32'($urandom), 32'($urandom)}
                                               : seg_base + {32'd0, seg_limit} + dlt;
            check("R9 random", exp_cause());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule